// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the byte stream of a received Ethernet frame and decides, from the first six bytes (the destination address), whether the frame is kept or dropped. A byte is taken on any clock where `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks its last byte. Once the sixth destination byte has been taken, one decision is raised and held. When `dec_discard` is high, a downstream receive FIFO can drop the frame without the processor stepping in.

Five configuration inputs control the decision: a 48-bit station address, a 64-bit hash table for individual addresses, a 64-bit hash table for group addresses, a broadcast-reject bit and a promiscuous bit. The block copies all five on the start-of-frame byte and uses that copy for the whole frame.

A three-state machine controls the block:
- `ST_IDLE` is the state after reset. The block stays there until a start-of-frame byte arrives.
- `ST_ADDR` collects destination bytes. Transition *enter-addr* goes from `ST_IDLE` or `ST_HELD` to `ST_ADDR` on a start-of-frame byte.
- Transition *decide* goes from `ST_ADDR` to `ST_HELD` on the sixth byte.
- Transition *runt-end* goes to `ST_HELD` when an end-of-frame byte arrives before six bytes are complete. This can happen on the start-of-frame byte itself, from any state.
- `ST_HELD` keeps the decision. Transition *restart* leaves `ST_HELD` on the next start-of-frame byte.

A start-of-frame byte seen in `ST_ADDR` restarts collection.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: When the promiscuous bit captured at start of frame is 1, every frame that delivers all six destination bytes is accepted.
- R2: A destination whose first byte has bit 0 equal to 0 (individual) is accepted when it equals the station address. Destination byte k is compared with `cfg_station_addr[8k+7:8k]`, and byte 0 is the first byte received.
- R3: An individual destination that is not an exact match is accepted when bit `h` of `cfg_ind_hash` is 1. The index `h` is found as follows:
  - Start a 32-bit register at all ones.
  - Shift in the 48 destination bits, byte 0 first and each byte least significant bit first.
  - For each bit, take feedback = reg[31] XOR the bit, shift the register left by one, and XOR in 0x04C11DB7 when the feedback is 1.
  - `h` is bits 31:26 of the final register, with no inversion.
- R4: A destination with bit 0 of byte 0 equal to 1, other than broadcast, is a group address. It is accepted only when bit `h` of `cfg_grp_hash` is 1. The individual table and the station address play no part in this decision.
- R5: A destination of all 48 ones is broadcast. It is accepted when `cfg_bcast_reject` is 0 and rejected when it is 1, whatever the group hash table holds.
- R6: A frame whose `rx_eof` byte comes before the sixth destination byte is rejected, even in promiscuous mode. Its decision is valid one clock after that byte. `dec_discard` is 1 exactly when a valid decision is a reject.
- R7: The decision is valid one clock after the sixth destination byte is taken, and not before. Clocks with `rx_valid` low are not counted as bytes.
- R8: A decision stays valid and unchanged, through any later payload bytes and idle clocks, until a start-of-frame byte is taken. One clock after that byte, `dec_valid` is 0.
- R9: A change to any configuration input after the start-of-frame byte has no effect on that frame's decision.
- R10: After reset `dec_valid` and `dec_discard` are 0. Bytes with `rx_sof` low taken in the idle state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte on `rx_data` is taken this clock |
| rx_sof | input | 1 | Taken byte is the first of a frame |
| rx_eof | input | 1 | Taken byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| cfg_station_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| cfg_ind_hash | input | 64 | Individual-address hash table |
| cfg_grp_hash | input | 64 | Group-address hash table |
| cfg_bcast_reject | input | 1 | 1 rejects broadcast frames |
| cfg_promisc | input | 1 | 1 accepts every complete destination |
| dec_valid | output | 1 | Decision for the current frame is available |
| dec_accept | output | 1 | Frame accepted (meaningful with `dec_valid`) |
| dec_discard | output | 1 | Frame must be dropped from the receive FIFO |

## Verification
Each verdict (`dec_valid`, `dec_accept`, `dec_discard`) is due in the first clock after the sixth valid byte, or after a runt's end-of-frame byte. The verdict is withdrawn in the first clock after the next start-of-frame byte.

The bench drives every byte half a period before an edge and reads the outputs half a period after it. A check made right after the edge that takes a byte therefore sees that byte's effect, and nothing later. The bench also reads `dec_valid` after the fifth byte, to show that the verdict is not early. It reads the verdict again through payload and idle clocks, to show that it is held.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int HASH_W     = 6;
    localparam int TABLE_N    = 1 << HASH_W;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_HELD = 2'd2
    } flt_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  station;
        logic [TABLE_N-1:0] ind_tbl;
        logic [TABLE_N-1:0] grp_tbl;
        logic               bcast_rej;
        logic               promisc;
    } flt_cfg_t;
endpackage

// File: rtl/eaf_crc_byte.sv
module eaf_crc_byte #(
    parameter int CRC_W = 32,
    parameter int DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic fb;
        acc = crc_in;
        for (int b = 0; b < DATA_W; b++) begin
            fb  = acc[CRC_W-1] ^ data[b];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/eaf_addr_capture.sv
module eaf_addr_capture
    import eaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              take,
    input  logic [BYTE_W-1:0] data,
    output logic [ADDR_W-1:0] addr_nx,
    output logic [HASH_W-1:0] hash_nx,
    output logic [CNT_W-1:0]  cnt_nx
);
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CRC_W-1:0]  crc_seed;
    logic [CRC_W-1:0]  crc_step;
    logic              load;

    assign load     = restart | take;
    assign crc_seed = restart ? {CRC_W{1'b1}} : crc_q;

    eaf_crc_byte #(
        .CRC_W (CRC_W),
        .DATA_W(BYTE_W),
        .POLY  (CRC_POLY)
    ) u_crc (
        .crc_in (crc_seed),
        .data   (data),
        .crc_out(crc_step)
    );

    always_comb begin
        if (restart) begin
            addr_nx = {data, {(ADDR_W-BYTE_W){1'b0}}};
            cnt_nx  = CNT_W'(1);
        end else begin
            addr_nx = {data, addr_q[ADDR_W-1:BYTE_W]};
            cnt_nx  = take ? cnt_q + CNT_W'(1) : cnt_q;
        end
        hash_nx = crc_step[CRC_W-1 -: HASH_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            crc_q  <= '1;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= addr_nx;
            crc_q  <= crc_step;
            cnt_q  <= cnt_nx;
        end
    end

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/eaf_decide.sv
module eaf_decide
    import eaf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [HASH_W-1:0] hash_idx,
    input  flt_cfg_t          cfg,
    output logic              accept
);
    logic is_bcast;
    logic is_grp;
    logic exact;

    assign is_bcast = &addr;
    assign is_grp   = addr[0];
    assign exact    = (addr == cfg.station);

    always_comb begin
        if (cfg.promisc)
            accept = 1'b1;
        else if (is_bcast)
            accept = ~cfg.bcast_rej;
        else if (is_grp)
            accept = cfg.grp_tbl[hash_idx];
        else
            accept = exact | cfg.ind_tbl[hash_idx];
    end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import eaf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic [ADDR_W-1:0]  cfg_station_addr,
    input  logic [TABLE_N-1:0] cfg_ind_hash,
    input  logic [TABLE_N-1:0] cfg_grp_hash,
    input  logic               cfg_bcast_reject,
    input  logic               cfg_promisc,
    output logic               dec_valid,
    output logic               dec_accept,
    output logic               dec_discard
);
    flt_state_t        state_q, state_nx;
    flt_cfg_t          cfg_q;
    logic              sof_take;
    logic              byte_take;
    logic              finish;
    logic              early_end;
    logic              runt_q;
    logic              accept_w;
    logic [ADDR_W-1:0] addr_nx;
    logic [HASH_W-1:0] hash_nx;
    logic [CNT_W-1:0]  cnt_nx;

    assign sof_take  = rx_valid & rx_sof;
    assign byte_take = rx_valid & ~rx_sof & (state_q == ST_ADDR);
    assign early_end = rx_eof & (cnt_nx < CNT_W'(ADDR_BYTES));
    assign finish    = (sof_take | byte_take) &
                       ((cnt_nx == CNT_W'(ADDR_BYTES)) | rx_eof);

    eaf_addr_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(sof_take),
        .take   (byte_take),
        .data   (rx_data),
        .addr_nx(addr_nx),
        .hash_nx(hash_nx),
        .cnt_nx (cnt_nx)
    );

    eaf_decide u_dec (
        .addr    (addr_nx),
        .hash_idx(hash_nx),
        .cfg     (cfg_q),
        .accept  (accept_w)
    );

    // configuration snapshot taken on the start-of-frame byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (sof_take)
            cfg_q <= '{station:   cfg_station_addr,
                       ind_tbl:   cfg_ind_hash,
                       grp_tbl:   cfg_grp_hash,
                       bcast_rej: cfg_bcast_reject,
                       promisc:   cfg_promisc};
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (finish)        state_nx = ST_HELD;
                else if (sof_take) state_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (finish)        state_nx = ST_HELD;
            end
            ST_HELD: begin
                if (finish)        state_nx = ST_HELD;
                else if (sof_take) state_nx = ST_ADDR;
            end
            default:               state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            runt_q     <= 1'b0;
        end else if (finish) begin
            dec_valid  <= 1'b1;
            dec_accept <= ~early_end & accept_w;
            runt_q     <= early_end;
        end else if (sof_take) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            runt_q     <= 1'b0;
        end
    end

    assign dec_discard = dec_valid & ~dec_accept;

    a_r7_due_on_sixth: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_take && cnt_nx == CNT_W'(ADDR_BYTES)) |=> dec_valid);

    a_r6_runt_reject: assert property (@(posedge clk) disable iff (!rst_n)
        ((sof_take || byte_take) && early_end) |=> (dec_valid && dec_discard));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !sof_take) |=> (dec_valid && $stable(dec_accept)));

    a_r8_clear_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_take && !rx_eof) |=> !dec_valid);

    a_r1_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dec_valid) && cfg_q.promisc && !runt_q) |-> dec_accept);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !dec_valid);
endmodule

// File: tb/sim_eth_rx_addr_filter.sv
module sim_eth_rx_addr_filter;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h66_55_44_33_22_02;
    localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;

    typedef struct packed {
        logic [47:0] addr;
        logic        promisc;
        logic        brej;
        logic [1:0]  ihm;   // 0 none, 1 all, 2 only own index, 3 all but own
        logic [1:0]  ghm;
        logic        exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{STATION,               1'b0, 1'b0, 2'd0, 2'd0, 1'b1}, // R2
        '{48'hA1_B2_C3_D4_E5_04, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0}, // R3 miss
        '{48'hA1_B2_C3_D4_E5_04, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R3 hit
        '{48'hA1_B2_C3_D4_E5_04, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0}, // R3 other bits
        '{48'h0A_00_5E_00_00_01, 1'b0, 1'b0, 2'd0, 2'd2, 1'b1}, // R4 hit
        '{48'h0A_00_5E_00_00_01, 1'b0, 1'b0, 2'd1, 2'd3, 1'b0}, // R4 miss
        '{48'h0A_00_5E_00_00_01, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0}, // R4 ind table unused
        '{48'h77_66_55_44_33_10, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0}, // R3 grp table unused
        '{BCAST,                 1'b0, 1'b0, 2'd0, 2'd0, 1'b1}, // R5 accept
        '{BCAST,                 1'b0, 1'b1, 2'd1, 2'd1, 1'b0}, // R5 reject wins
        '{48'h77_66_55_44_33_10, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1}, // R1
        '{BCAST,                 1'b1, 1'b1, 2'd0, 2'd0, 1'b1}, // R1 over R5
        '{STATION,               1'b0, 1'b0, 2'd3, 2'd0, 1'b1}  // R2 no hash needed
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [47:0] cfg_station_addr = STATION;
    logic [63:0] cfg_ind_hash = '0, cfg_grp_hash = '0;
    logic        cfg_bcast_reject = 1'b0, cfg_promisc = 1'b0;
    logic        dec_valid, dec_accept, dec_discard;
    int          n_checks = 0;
    int          n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .cfg_station_addr(cfg_station_addr),
        .cfg_ind_hash(cfg_ind_hash), .cfg_grp_hash(cfg_grp_hash),
        .cfg_bcast_reject(cfg_bcast_reject), .cfg_promisc(cfg_promisc),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_discard(dec_discard)
    );

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = r[31] ^ a[i];
            r = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C1_1DB7;
        end
        return r[31:26];
    endfunction

    function automatic logic [63:0] tbl(input logic [1:0] m, input logic [5:0] i);
        case (m)
            2'd0:    return 64'd0;
            2'd1:    return ~64'd0;
            2'd2:    return 64'd1 << i;
            default: return ~(64'd1 << i);
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one clock of input, return after the edge that takes it
    task automatic put(input logic v, input logic s, input logic e, input logic [7:0] d);
        rx_valid = v; rx_sof = s; rx_eof = e; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic verdict(input string tag, input logic exp);
        check({tag, " valid"}, 64'(dec_valid), 64'd1);
        check({tag, " accept"}, 64'(dec_accept), 64'(exp));
        check({tag, " discard"}, 64'(dec_discard), 64'(!exp));
    endtask

    task automatic frame(input logic [47:0] a, input logic exp, input bit gaps, input string tag);
        for (int k = 0; k < 6; k++) begin
            put(1'b1, k == 0, 1'b0, a[8*k +: 8]);
            if (k == 0) check({tag, " R8 cleared by sof"}, 64'(dec_valid), 64'd0);
            if (k == 4) check({tag, " R7 not early"}, 64'(dec_valid), 64'd0);
            if (gaps && k < 5) begin
                put(1'b0, 1'b0, 1'b0, 8'hEE);
                check({tag, " R7 gap"}, 64'(dec_valid), 64'd0);
            end
        end
        verdict(tag, exp);
        put(1'b1, 1'b0, 1'b0, 8'hFF);
        put(1'b0, 1'b0, 1'b0, 8'h00);
        put(1'b1, 1'b1 & 1'b0, 1'b1, 8'h01);
        verdict({tag, " R8 held"}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", 64'(dec_valid), 64'd0);
        check("R10 reset discard", 64'(dec_discard), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // bytes with no start-of-frame while idle
        for (int k = 0; k < 8; k++) put(1'b1, 1'b0, k == 7, 8'hFF);
        check("R10 idle bytes ignored", 64'(dec_valid), 64'd0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            cfg_promisc      = VECS[i].promisc;
            cfg_bcast_reject = VECS[i].brej;
            cfg_ind_hash     = tbl(VECS[i].ihm, hidx(VECS[i].addr));
            cfg_grp_hash     = tbl(VECS[i].ghm, hidx(VECS[i].addr));
            frame(VECS[i].addr, VECS[i].exp, 1'b0, $sformatf("vec%0d R1-5", i));
        end

        // R7 with idle clocks between destination bytes
        cfg_promisc = 1'b0; cfg_ind_hash = '0; cfg_grp_hash = '0;
        frame(STATION, 1'b1, 1'b1, "R7 gaps");

        // R8 hold over many idle clocks
        repeat (7) put(1'b0, 1'b0, 1'b0, 8'h00);
        verdict("R8 idle hold", 1'b1);

        // R6 runt in promiscuous mode
        cfg_promisc = 1'b1;
        put(1'b1, 1'b1, 1'b0, 8'h02);
        put(1'b1, 1'b0, 1'b0, 8'h22);
        check("R6 runt not yet", 64'(dec_valid), 64'd0);
        put(1'b1, 1'b0, 1'b1, 8'h33);
        verdict("R6 runt", 1'b0);
        put(1'b0, 1'b0, 1'b0, 8'h00);
        verdict("R6 runt held", 1'b0);

        // R6 single-byte frame
        put(1'b1, 1'b1, 1'b1, 8'h02);
        verdict("R6 one byte", 1'b0);

        // R9 promiscuous turned on after sof
        cfg_promisc = 1'b0;
        put(1'b1, 1'b1, 1'b0, 8'h10);
        cfg_promisc = 1'b1; cfg_ind_hash = '1; cfg_grp_hash = '1;
        for (int k = 1; k < 6; k++) put(1'b1, 1'b0, 1'b0, 8'h20 + 8'(k));
        verdict("R9 late promisc", 1'b0);

        // R9 station changed after sof
        cfg_promisc = 1'b0; cfg_ind_hash = '0; cfg_grp_hash = '0;
        cfg_station_addr = STATION;
        put(1'b1, 1'b1, 1'b0, STATION[7:0]);
        cfg_station_addr = 48'h11_11_11_11_11_10;
        for (int k = 1; k < 6; k++) put(1'b1, 1'b0, 1'b0, STATION[8*k +: 8]);
        verdict("R9 late station", 1'b1);

        // R9 broadcast reject raised after sof
        cfg_bcast_reject = 1'b0;
        put(1'b1, 1'b1, 1'b0, 8'hFF);
        cfg_bcast_reject = 1'b1;
        for (int k = 1; k < 6; k++) put(1'b1, 1'b0, 1'b0, 8'hFF);
        verdict("R9 late bcast reject", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule